// File: doc/BRIEF.md
# Indirect Lookup Table Access Port

This block is the register front end of an address lookup table whose entries are 68 bits wide, wider than the 32-bit bus that software uses. Software never addresses the table directly. It stages an entry in three data word registers and then writes a table control register. That write carries an index and a direction flag. With the flag clear, the indexed entry is copied into the data words, ready to be read back. With the flag set, the data words are stored into the indexed entry.

The staged entry is split in reverse order. The lowest data word offset holds the four top entry bits, the middle offset holds bits 63:32, and the highest offset holds bits 31:0. A global control register holds an enable bit and a clear bit. Setting the clear bit starts a sweep that writes zero, the free entry type, into every entry at a rate of one entry per clock. An identification register reports a version number. The table depth and the version are parameters.

Top module: `lut_access_port`

## Requirements
- R1: After reset, offsets 0x08, 0x20, 0x34, 0x38 and 0x3C read zero. Offset 0x00 always reads {16'h0, VER_MAJOR[7:0], VER_MINOR[7:0]}.
- R2: Data words at 0x34, 0x38 and 0x3C read back what was last written. The word at 0x34 keeps only bits 3:0, and its bits 31:4 read zero.
- R3: A write to 0x20 with bit 31 set and an in-range index in bits 30:0 stores an entry into the table. The entry is {word@0x34[3:0], word@0x38, word@0x3C}, with entry bits 67:64, 63:32 and 31:0 in that order.
- R4: A write to 0x20 with bit 31 clear loads the indexed entry into the three data words on the clock edge of that write, so the next bus cycle reads it. Offset 0x20 then reads the index in bits 30:0 with bit 31 zero.
- R5: An index at or above DEPTH, including one whose low bits alias a real entry, changes no entry when stored. When loaded, it sets all three data words to zero.
- R6: A write to 0x08 with bit 30 set starts a clear sweep of one entry per cycle. Bit 30 of 0x08 reads 1 for exactly DEPTH cycles after that write and then reads 0. After the sweep, every entry loads as zero.
- R7: While a sweep runs, writes to 0x20 are ignored. The data words and the table keep their values.
- R8: Bit 31 of 0x08 reads back the last value written to it, and neither starting nor finishing a sweep changes it.
- R9: Offsets with no register read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |

## Verification
The assertions assume at most one bus access per cycle. They also assume that no software write to 0x08 tries to start a second sweep while one is running. The stimulus drives a single access per clock from one driver and starts only one sweep. The properties on the hold-off and the out-of-range load compare the data words one cycle after a table control write. This relies on no data word write landing in that same cycle, and the stimulus guarantees it because it issues strictly serial accesses.

// File: rtl/lut_access_port.sv
module lut_access_port #(
  parameter int DEPTH = 1024,
  parameter logic [7:0] VER_MAJOR = 8'd1,
  parameter logic [7:0] VER_MINOR = 8'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [7:0] OFS_ID = 8'h00, OFS_GCTL = 8'h08, OFS_TCTL = 8'h20;
  localparam logic [7:0] OFS_W0 = 8'h34, OFS_W1 = 8'h38, OFS_W2 = 8'h3C;

  logic [67:0]      mem [DEPTH];
  logic [3:0]       w0;
  logic [31:0]      w1, w2;
  logic [30:0]      tbl_idx;
  logic             enable, busy;
  logic [IDX_W-1:0] sweep_cnt;

  wire             wr_en   = bus_sel & bus_wr;
  wire             tctl_wr = wr_en && bus_addr == OFS_TCTL && !busy;
  wire             idx_ok  = bus_wdata[30:0] < 31'(DEPTH);
  wire [IDX_W-1:0] widx    = bus_wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (busy)
      mem[sweep_cnt] <= '0;
    else if (tctl_wr && bus_wdata[31] && idx_ok)
      mem[widx] <= {w0, w1, w2};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w0 <= '0;
      w1 <= '0;
      w2 <= '0;
      tbl_idx <= '0;
      enable <= 1'b0;
      busy <= 1'b0;
      sweep_cnt <= '0;
    end else begin
      if (busy) begin
        if (sweep_cnt == LAST) busy <= 1'b0;
        else sweep_cnt <= sweep_cnt + 1'b1;
      end
      if (wr_en) begin
        case (bus_addr)
          OFS_GCTL: begin
            enable <= bus_wdata[31];
            if (bus_wdata[30] && !busy) begin
              busy <= 1'b1;
              sweep_cnt <= '0;
            end
          end
          OFS_W0: w0 <= bus_wdata[3:0];
          OFS_W1: w1 <= bus_wdata;
          OFS_W2: w2 <= bus_wdata;
          default: ;
        endcase
      end
      if (tctl_wr) begin
        tbl_idx <= bus_wdata[30:0];
        if (!bus_wdata[31])
          {w0, w1, w2} <= idx_ok ? mem[widx] : 68'h0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_ID:   bus_rdata = {16'h0, VER_MAJOR, VER_MINOR};
        OFS_GCTL: bus_rdata = {enable, busy, 30'h0};
        OFS_TCTL: bus_rdata = {1'b0, tbl_idx};
        OFS_W0:   bus_rdata = {28'h0, w0};
        OFS_W1:   bus_rdata = w1;
        OFS_W2:   bus_rdata = w2;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lut_access_port_chk.sv
module lut_access_port_chk #(
  parameter int DEPTH = 1024,
  parameter logic [7:0] VER_MAJOR = 8'd1,
  parameter logic [7:0] VER_MINOR = 8'd2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_sel,
  input logic                      bus_wr,
  input logic [7:0]                bus_addr,
  input logic [31:0]               bus_wdata,
  input logic [31:0]               bus_rdata,
  input logic                      busy,
  input logic [$clog2(DEPTH)-1:0]  sweep_cnt,
  input logic [3:0]                w0,
  input logic [31:0]               w1,
  input logic [31:0]               w2
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  // R1
  id_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 8'h00) |-> bus_rdata == {16'h0, VER_MAJOR, VER_MINOR});

  // R2
  w0_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 8'h34) |-> bus_rdata[31:4] == 28'h0);

  // R5
  oob_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_sel && bus_wr && bus_addr == 8'h20 && !bus_wdata[31] &&
     bus_wdata[30:0] >= 31'(DEPTH)) |=> (w0 == 4'h0 && w1 == 32'h0 && w2 == 32'h0));

  // R6
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_sel && bus_wr && bus_addr == 8'h08 && bus_wdata[30]) |=> (busy && sweep_cnt == '0));

  // R6
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sweep_cnt != LAST) |=> (busy && sweep_cnt == IDX_W'($past(sweep_cnt) + 1'b1)));

  // R6
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sweep_cnt == LAST) |=> !busy);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_sel && bus_wr && bus_addr == 8'h20) |=> ($stable(w0) && $stable(w1) && $stable(w2)));
endmodule

bind lut_access_port lut_access_port_chk #(.DEPTH(DEPTH), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) i_chk (.*);

// File: tb/test_lut_access_port.sv
module test_lut_access_port;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0, failures = 0, ncyc = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  lut_access_port #(.DEPTH(DEPTH)) i_lut_access_port (.*);

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    ncyc++;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    ncyc++;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    ncyc++;
  endtask

  task automatic stage(input logic [3:0] a, input logic [31:0] b, input logic [31:0] c);
    wr_reg(8'h34, {28'h0, a});
    wr_reg(8'h38, b);
    wr_reg(8'h3C, c);
  endtask

  task automatic expect_words(input logic [3:0] a, input logic [31:0] b, input logic [31:0] c, input string tag);
    rd_exp(8'h34, {28'h0, a}, tag);
    rd_exp(8'h38, b, tag);
    rd_exp(8'h3C, c, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (bus_sel && !bus_wr && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    int n0;
    repeat (3) idle();
    @(negedge clk); rst_n = 1'b1;

    rd_exp(8'h00, 32'h0000_0102, "R1 id");
    rd_exp(8'h08, 32'h0, "R1 gctl");
    rd_exp(8'h20, 32'h0, "R1 tctl");
    expect_words(4'h0, 32'h0, 32'h0, "R1 data");

    wr_reg(8'h34, 32'hFFFF_FFFA);
    wr_reg(8'h38, 32'h1234_5678);
    wr_reg(8'h3C, 32'h9ABC_DEF0);
    expect_words(4'hA, 32'h1234_5678, 32'h9ABC_DEF0, "R2 readback");

    wr_reg(8'h20, 32'h8000_0000);
    stage(4'h5, 32'h1111_1111, 32'h2222_2222);
    wr_reg(8'h20, 32'h8000_0000 | (DEPTH - 1));
    stage(4'h3, 32'hCAFE_F00D, 32'h0BAD_BEEF);
    wr_reg(8'h20, 32'h8000_0007);
    stage(4'h0, 32'h0, 32'h0);

    wr_reg(8'h20, 32'h0000_0000);
    expect_words(4'hA, 32'h1234_5678, 32'h9ABC_DEF0, "R3 entry0");
    rd_exp(8'h20, 32'h0, "R4 index readback");
    wr_reg(8'h20, DEPTH - 1);
    rd_exp(8'h34, 32'h5, "R4 immediate load");
    rd_exp(8'h38, 32'h1111_1111, "R3 entry last");
    rd_exp(8'h3C, 32'h2222_2222, "R3 entry last");
    rd_exp(8'h20, DEPTH - 1, "R4 index readback");
    wr_reg(8'h20, 32'h0000_0007);
    expect_words(4'h3, 32'hCAFE_F00D, 32'h0BAD_BEEF, "R4 entry7");

    stage(4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr_reg(8'h20, 32'h8000_0000 | DEPTH);
    wr_reg(8'h20, 32'h0000_0000);
    expect_words(4'hA, 32'h1234_5678, 32'h9ABC_DEF0, "R5 alias store ignored");
    wr_reg(8'h20, DEPTH);
    expect_words(4'h0, 32'h0, 32'h0, "R5 oob load zero");
    stage(4'h1, 32'h1, 32'h1);
    wr_reg(8'h20, 32'h7FFF_FFFF);
    expect_words(4'h0, 32'h0, 32'h0, "R5 max index load zero");

    wr_reg(8'h44, 32'hFFFF_FFFF);
    rd_exp(8'h44, 32'h0, "R9 unmapped");
    rd_exp(8'h04, 32'h0, "R9 unmapped");
    rd_exp(8'h08, 32'h0, "R9 gctl untouched");

    wr_reg(8'h20, 32'h0000_0007);
    wr_reg(8'h08, 32'hC000_0000);
    n0 = ncyc;
    rd_exp(8'h08, 32'hC000_0000, "R6 busy set");
    wr_reg(8'h20, 32'h0000_0000);
    expect_words(4'h3, 32'hCAFE_F00D, 32'h0BAD_BEEF, "R7 load held off");
    rd_exp(8'h20, 32'h7, "R7 index held");
    while (ncyc < n0 + DEPTH - 1) idle();
    rd_exp(8'h08, 32'hC000_0000, "R6 busy last cycle");
    rd_exp(8'h08, 32'h8000_0000, "R6 busy cleared R8 enable kept");

    wr_reg(8'h20, 32'h0000_0000);
    expect_words(4'h0, 32'h0, 32'h0, "R6 entry0 freed");
    wr_reg(8'h20, DEPTH - 1);
    expect_words(4'h0, 32'h0, 32'h0, "R6 last freed");
    wr_reg(8'h20, 32'h0000_0007);
    expect_words(4'h0, 32'h0, 32'h0, "R6 entry7 freed");

    wr_reg(8'h08, 32'h0);
    rd_exp(8'h08, 32'h0, "R8 enable off");

    idle(); idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule